// File: doc/BRIEF.md
# Chained Up/Down Timer Pair with Toggle Stage

This block joins two 16-bit up/down counters into one wide timer/counter. The low-order "core" counter counts prescaled clock-enable pulses, gated pulses, or edges of an external input. Each time it wraps, in either direction, it inverts a single toggle bit. The high-order "auxiliary" counter counts selected transitions of that toggle bit, or of its own external input. Counting both transitions of the toggle bit makes a 32-bit chain. Counting only one of them makes a 33-bit chain, with the toggle bit as bit 16.

Software can load both counters and the toggle bit at any time, and it can read them back. A write always overrides a count or toggle event that falls in the same cycle. Each counter raises a one-cycle interrupt request when it wraps. The whole block runs on one clock. Every edge, including the edges of the toggle bit, is detected synchronously.

Top module: `gpt_chain_timer`

## Requirements
- R1: After synchronous reset, both counters read 0x0000, the toggle bit reads 0, and both interrupt outputs are low.
- R2: With core_mode = 0 (timer) and core_run = 1, the core counter changes by one at each clock edge where clk_en is high. It counts up when core_dir_down = 0 and down when core_dir_down = 1.
- R3: With core_mode = 1 (gated), the core counter counts clk_en pulses only while the synchronized gate input equals gate_active_high. The gate input passes through a two-flop synchronizer.
- R4: With core_mode = 2 (counter), the core counter counts edges of core_ext_in selected by core_ext_edge (0 none, 1 rising, 2 falling, 3 both). The count appears three clock edges after the input changes.
- R5: A core up-count from 0xFFFF to 0x0000, or down-count from 0x0000 to 0xFFFF, inverts the toggle bit and pulses core_irq for exactly one cycle, on the same edge that the value wraps.
- R6: With aux_src_latch = 1, the auxiliary counter counts toggle-bit transitions selected by aux_edge (0 none, 1 rising, 2 falling, 3 both). Each count lands one clock edge after the toggle bit changes. Code 3 gives a 32-bit chain; codes 1 and 2 give a 33-bit chain.
- R7: With aux_src_latch = 0, the auxiliary counter counts transitions of aux_ext_in selected by aux_edge. Each count appears three clock edges after the input changes.
- R8: The two directions are independent. The auxiliary counter counts up or down according to aux_dir_down, and pulses aux_irq for one cycle when it wraps.
- R9: A counter whose run bit is 0 holds its value whatever its count inputs do.
- R10: A counter write (core_wr or aux_wr) loads its wdata on the next edge, even if a count event falls in that cycle. A toggle write (tl_wr) sets the toggle bit to tl_wdata, even if a core wrap falls in that cycle.
- R11: A toggle write that changes the toggle bit is a transition like any other. With the auxiliary counter running on the toggle source, it counts according to aux_edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Prescaled count enable |
| core_ext_in | input | 1 | External count input of the core counter |
| core_gate_in | input | 1 | Gate input of the core counter |
| aux_ext_in | input | 1 | External count input of the auxiliary counter |
| core_run | input | 1 | Core counter run bit |
| core_dir_down | input | 1 | Core direction, 1 = down |
| core_mode | input | 2 | 0 timer, 1 gated, 2 counter |
| core_ext_edge | input | 2 | Edge select for counter mode |
| gate_active_high | input | 1 | Gate level that enables counting |
| aux_run | input | 1 | Auxiliary counter run bit |
| aux_dir_down | input | 1 | Auxiliary direction, 1 = down |
| aux_src_latch | input | 1 | 1 = toggle bit, 0 = aux_ext_in |
| aux_edge | input | 2 | Edge select of auxiliary source |
| core_wr | input | 1 | Core counter write strobe |
| core_wdata | input | 16 | Core counter write value |
| aux_wr | input | 1 | Auxiliary counter write strobe |
| aux_wdata | input | 16 | Auxiliary counter write value |
| tl_wr | input | 1 | Toggle bit write strobe |
| tl_wdata | input | 1 | Toggle bit write value |
| core_value | output | 16 | Core counter value |
| aux_value | output | 16 | Auxiliary counter value |
| tl_value | output | 1 | Toggle bit |
| core_irq | output | 1 | Core wrap pulse |
| aux_irq | output | 1 | Auxiliary wrap pulse |

## Verification
Two pairs of functions can fall in the same cycle. A software load of the core counter can coincide with a count pulse. A software write of the toggle bit can coincide with the core wrap that would otherwise flip it. The bench provokes each pair by raising the write strobe and clk_en on the same edge. For the load, it judges that the loaded value appears and the count is lost. For the toggle bit, it presets the counter to 0xFFFF so that a wrap would flip the bit, then judges that the bit keeps the written value while the core still wraps and raises its interrupt. It also judges that the auxiliary counter does not move, because the toggle bit saw no transition.

// File: rtl/gpt_chain_pkg.sv
package gpt_chain_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'd0,
        MODE_GATED   = 2'd1,
        MODE_COUNTER = 2'd2,
        MODE_IDLE    = 2'd3
    } core_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic edge_pick(edge_sel_e sel, edge_ev_t ev);
        case (sel)
            EDGE_RISE: return ev.rise;
            EDGE_FALL: return ev.fall;
            EDGE_BOTH: return ev.rise | ev.fall;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gpt_sync_level.sv
module gpt_sync_level #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge
    import gpt_chain_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     d,
    output edge_ev_t ev
);
    logic lvl;
    logic prev;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = d;
        end else begin : g_sync
            gpt_sync_level #(.STAGES(STAGES)) u_sync (
                .clk(clk), .rst(rst), .d(d), .q(lvl)
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign ev.rise = lvl & ~prev;
    assign ev.fall = ~lvl & prev;
endmodule

// File: rtl/gpt_ctr_unit.sv
module gpt_ctr_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ev,
    input  logic         dn,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         wrap,
    output logic         irq
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    assign wrap = ev & ~wr & (dn ? (q == '0) : (q == ALL1));

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            irq <= 1'b0;
        end else begin
            irq <= wrap;
            if (wr)      q <= wdata;
            else if (ev) q <= dn ? q - W'(1) : q + W'(1);
        end
    end

    // R10: load wins over count
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        wr |=> q == $past(wdata));
    // R2: up step
    a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
        (ev && !wr && !dn) |=> q == $past(q) + W'(1));
    // R2: down step
    a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
        (ev && !wr && dn) |=> q == $past(q) - W'(1));
    // R9: no event, no write, value holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!ev && !wr) |=> $stable(q));
    // R5: wrap gives a pulse
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        wrap |=> irq);
endmodule

// File: rtl/gpt_toggle_latch.sv
module gpt_toggle_latch (
    input  logic clk,
    input  logic rst,
    input  logic flip,
    input  logic wr,
    input  logic wdata,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (wr)   q <= wdata;
        else if (flip) q <= ~q;
    end

    // R10: write wins over flip
    a_r10_tl_write: assert property (@(posedge clk) disable iff (rst)
        wr |=> q == $past(wdata));
    // R5: flip inverts
    a_r5_tl_flip: assert property (@(posedge clk) disable iff (rst)
        (flip && !wr) |=> q != $past(q));
endmodule

// File: rtl/gpt_chain_timer.sv
module gpt_chain_timer
    import gpt_chain_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             core_ext_in,
    input  logic             core_gate_in,
    input  logic             aux_ext_in,
    input  logic             core_run,
    input  logic             core_dir_down,
    input  logic [1:0]       core_mode,
    input  logic [1:0]       core_ext_edge,
    input  logic             gate_active_high,
    input  logic             aux_run,
    input  logic             aux_dir_down,
    input  logic             aux_src_latch,
    input  logic [1:0]       aux_edge,
    input  logic             core_wr,
    input  logic [CNT_W-1:0] core_wdata,
    input  logic             aux_wr,
    input  logic [CNT_W-1:0] aux_wdata,
    input  logic             tl_wr,
    input  logic             tl_wdata,
    output logic [CNT_W-1:0] core_value,
    output logic [CNT_W-1:0] aux_value,
    output logic             tl_value,
    output logic             core_irq,
    output logic             aux_irq
);
    localparam int SYNC_N = 2;

    logic     gate_s;
    edge_ev_t core_x_ev, aux_x_ev, tl_ev, aux_src_ev;
    logic     core_ev, aux_ev, core_wrap, aux_wrap_unused_guard;

    gpt_sync_level #(.STAGES(SYNC_N)) u_gate_sync (
        .clk(clk), .rst(rst), .d(core_gate_in), .q(gate_s)
    );
    gpt_sync_edge #(.STAGES(SYNC_N)) u_core_x (
        .clk(clk), .rst(rst), .d(core_ext_in), .ev(core_x_ev)
    );
    gpt_sync_edge #(.STAGES(SYNC_N)) u_aux_x (
        .clk(clk), .rst(rst), .d(aux_ext_in), .ev(aux_x_ev)
    );
    gpt_sync_edge #(.STAGES(0)) u_tl_edge (
        .clk(clk), .rst(rst), .d(tl_value), .ev(tl_ev)
    );

    always_comb begin
        core_ev = 1'b0;
        case (core_mode_e'(core_mode))
            MODE_TIMER:   core_ev = clk_en;
            MODE_GATED:   core_ev = clk_en & (gate_s == gate_active_high);
            MODE_COUNTER: core_ev = edge_pick(edge_sel_e'(core_ext_edge), core_x_ev);
            default:      core_ev = 1'b0;
        endcase
        core_ev = core_ev & core_run;
    end

    assign aux_src_ev = aux_src_latch ? tl_ev : aux_x_ev;
    assign aux_ev     = aux_run & edge_pick(edge_sel_e'(aux_edge), aux_src_ev);

    gpt_ctr_unit #(.W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .ev(core_ev), .dn(core_dir_down),
        .wr(core_wr), .wdata(core_wdata),
        .q(core_value), .wrap(core_wrap), .irq(core_irq)
    );

    gpt_ctr_unit #(.W(CNT_W)) u_aux (
        .clk(clk), .rst(rst), .ev(aux_ev), .dn(aux_dir_down),
        .wr(aux_wr), .wdata(aux_wdata),
        .q(aux_value), .wrap(aux_wrap_unused_guard), .irq(aux_irq)
    );

    gpt_toggle_latch u_tl (
        .clk(clk), .rst(rst), .flip(core_wrap),
        .wr(tl_wr), .wdata(tl_wdata), .q(tl_value)
    );

    // R6: a toggle transition with both edges selected moves the aux counter next edge
    a_r6_chain_step: assert property (@(posedge clk) disable iff (rst)
        (aux_run && aux_src_latch && aux_edge == 2'd3 && !aux_wr &&
         tl_value != $past(tl_value)) |=> aux_value != $past(aux_value));
    // R9: stopped aux counter without write holds
    a_r9_aux_stop: assert property (@(posedge clk) disable iff (rst)
        (!aux_run && !aux_wr) |=> $stable(aux_value));
    // R8: aux wrap raises its pulse
    a_r8_aux_irq: assert property (@(posedge clk) disable iff (rst)
        aux_wrap_unused_guard |=> aux_irq);
    // R9: stopped core never wraps
    a_r9_core_stop: assert property (@(posedge clk) disable iff (rst)
        !core_run |-> !core_wrap);
endmodule

// File: tb/tb_gpt_chain_timer.sv
module tb_gpt_chain_timer;
    logic clk = 1'b0;
    logic rst;
    logic clk_en, core_ext_in, core_gate_in, aux_ext_in;
    logic core_run, core_dir_down, gate_active_high;
    logic [1:0] core_mode, core_ext_edge, aux_edge;
    logic aux_run, aux_dir_down, aux_src_latch;
    logic core_wr, aux_wr, tl_wr, tl_wdata;
    logic [15:0] core_wdata, aux_wdata, core_value, aux_value;
    logic tl_value, core_irq, aux_irq;

    int checks = 0;
    int failures = 0;
    int core_irq_n = 0;
    int aux_irq_n = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpt_chain_timer dut (.*);

    always @(negedge clk) begin
        if (core_irq) core_irq_n++;
        if (aux_irq)  aux_irq_n++;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            clk_en = 1; cyc(1); clk_en = 0; cyc(1);
        end
    endtask

    task automatic load(logic [15:0] c, logic [15:0] a, logic t);
        core_run = 0; aux_run = 0;
        tl_wr = 1; tl_wdata = t; cyc(1); tl_wr = 0; cyc(2);
        core_wr = 1; core_wdata = c; aux_wr = 1; aux_wdata = a;
        cyc(1); core_wr = 0; aux_wr = 0;
        core_irq_n = 0; aux_irq_n = 0;
    endtask

    task automatic t_reset;
        chk("R1 core", core_value, 0);
        chk("R1 aux", aux_value, 0);
        chk("R1 tl", tl_value, 0);
        chk("R1 irq", {core_irq, aux_irq}, 0);
    endtask

    task automatic t_chain32;
        load(16'hFFFD, 0, 0);
        core_mode = 0; aux_src_latch = 1; aux_edge = 3;
        core_dir_down = 0; aux_dir_down = 0;
        core_run = 1; aux_run = 1;
        pulses(5); cyc(1);
        chk("R2 core up", core_value, 16'h0002);
        chk("R5 tl flip", tl_value, 1);
        chk("R5 core irq once", core_irq_n, 1);
        chk("R6 32-bit aux", aux_value, 1);
    endtask

    task automatic t_chain33;
        load(16'hFFFF, 0, 0);
        aux_edge = 1; core_run = 1; aux_run = 1;
        pulses(1); cyc(1);
        chk("R6 rise counted", aux_value, 1);
        core_wr = 1; core_wdata = 16'hFFFF; cyc(1); core_wr = 0;
        pulses(1); cyc(1);
        chk("R6 fall ignored", aux_value, 1);
        chk("R6 tl middle bit", {aux_value, tl_value, core_value}, 33'h1_0000 >> 0 ? {16'h0001, 1'b0, 16'h0000} : 0);
    endtask

    task automatic t_down;
        load(16'h0001, 0, 0);
        aux_edge = 3; core_dir_down = 1; aux_dir_down = 1;
        core_run = 1; aux_run = 1;
        pulses(2); cyc(1);
        chk("R2 core down", core_value, 16'hFFFF);
        chk("R5 underflow flip", tl_value, 1);
        chk("R8 aux down wrap", aux_value, 16'hFFFF);
        chk("R8 aux irq", aux_irq_n, 1);
        core_dir_down = 0;
        pulses(1); cyc(1);
        chk("R8 mixed dirs core", core_value, 0);
        chk("R8 mixed dirs aux", aux_value, 16'hFFFE);
        aux_dir_down = 0;
    endtask

    task automatic t_gated;
        load(0, 0, 0);
        core_mode = 1; gate_active_high = 1; core_gate_in = 0; cyc(3);
        core_run = 1;
        pulses(4);
        chk("R3 gate closed", core_value, 0);
        core_gate_in = 1; cyc(3);
        pulses(4);
        chk("R3 gate open", core_value, 4);
        gate_active_high = 0;
        pulses(3);
        chk("R3 polarity low", core_value, 4);
        core_gate_in = 0; cyc(3);
        pulses(2);
        chk("R3 low level open", core_value, 6);
    endtask

    task automatic t_counter;
        load(0, 0, 0);
        core_mode = 2; core_ext_edge = 1; core_run = 1;
        for (int i = 0; i < 5; i++) begin
            core_ext_in = 1; cyc(3); core_ext_in = 0; cyc(3);
        end
        chk("R4 rising", core_value, 5);
        core_ext_edge = 3;
        core_ext_in = 1; cyc(3);
        chk("R4 latency", core_value, 6);
        core_ext_in = 0; cyc(3);
        chk("R4 both edges", core_value, 7);
        core_mode = 0;
    endtask

    task automatic t_auxext;
        load(0, 0, 0);
        aux_src_latch = 0; aux_edge = 1; aux_run = 1;
        for (int i = 0; i < 3; i++) begin
            aux_ext_in = 1; cyc(3); aux_ext_in = 0; cyc(3);
        end
        chk("R7 ext rising", aux_value, 3);
        aux_edge = 3;
        aux_ext_in = 1; cyc(3); aux_ext_in = 0; cyc(3);
        chk("R7 ext both", aux_value, 5);
        aux_src_latch = 1;
    endtask

    task automatic t_priority;
        load(16'd10, 16'd7, 1);
        core_mode = 0; aux_edge = 3; core_run = 1; aux_run = 1;
        clk_en = 1; core_wr = 1; core_wdata = 16'h1234; cyc(1);
        clk_en = 0; core_wr = 0;
        chk("R10 write beats count", core_value, 16'h1234);
        core_wr = 1; core_wdata = 16'hFFFF; cyc(1); core_wr = 0;
        clk_en = 1; tl_wr = 1; tl_wdata = 1; cyc(1);
        clk_en = 0; tl_wr = 0; cyc(1);
        chk("R10 tl write beats wrap", tl_value, 1);
        chk("R10 core still wrapped", core_value, 0);
        chk("R10 core irq", core_irq_n, 1);
        chk("R10 aux unmoved", aux_value, 7);
    endtask

    task automatic t_run;
        load(16'd3, 16'd9, 0);
        aux_edge = 3;
        pulses(4);
        chk("R9 core stopped", core_value, 3);
        tl_wr = 1; tl_wdata = 1; cyc(1); tl_wr = 0; cyc(2);
        chk("R9 aux stopped", aux_value, 9);
        aux_run = 1;
        tl_wr = 1; tl_wdata = 0; cyc(1); tl_wr = 0; cyc(2);
        chk("R11 tl write counts", aux_value, 10);
        aux_edge = 1;
        tl_wr = 1; tl_wdata = 0; cyc(1); tl_wr = 0; cyc(2);
        chk("R11 no change no count", aux_value, 10);
    endtask

    initial begin
        rst = 1; clk_en = 0; core_ext_in = 0; core_gate_in = 0; aux_ext_in = 0;
        core_run = 0; core_dir_down = 0; core_mode = 0; core_ext_edge = 0;
        gate_active_high = 1; aux_run = 0; aux_dir_down = 0; aux_src_latch = 1;
        aux_edge = 0; core_wr = 0; core_wdata = 0; aux_wr = 0; aux_wdata = 0;
        tl_wr = 0; tl_wdata = 0;
        cyc(3); rst = 0; cyc(1);
        t_reset();
        t_chain32();
        t_chain33();
        t_down();
        t_gated();
        t_counter();
        t_auxext();
        t_priority();
        t_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule